// File: doc/BRIEF.md
# Display Status Register and Interrupt Request

This block keeps the status register of a raster display controller and turns its contents into a single interrupt request for the interrupt-flag logic. Each cycle it takes the display mode, the scan-line counter, the line-compare value and the display-enable bit. It registers all of them and from them derives a line-match flag. The CPU can write four source-enable bits. The stored fields are returned on a read port.

The request is edge based. A pulse one cycle wide is emitted when the OR of all enabled sources goes from false to true. A source that stays true does not request again. Turning the display off blocks every request.

A legacy-compatibility input models an older quirk. When this input is set, a CPU write to the status register during mode 0 or mode 1 raises a request of its own, whatever bits are written.

Top module: `lcd_stat_irq`

## Requirements
- R1: While reset is held, the read value is 0x80 and no request is driven.
- R2: The read value has bit 7 always 1, bits 6:3 the last written enables, bit 2 the line-match flag and bits 1:0 the mode. Written bits 7 and 2:0 are ignored. A write shows on the read port one cycle later.
- R3: Bit 2 is 1 exactly when the line counter equalled the compare value one cycle earlier, and 0 otherwise.
- R4: With enable bit 6 set, the line counter becoming equal to the compare value produces a one-cycle request two cycles after the inputs change.
- R5: Enable bit 3 makes mode 0 a source, bit 4 makes mode 1 a source and bit 5 makes mode 2 a source. Mode 3 is never a source, and a mode whose enable is clear raises nothing.
- R6: A request occurs only on a false-to-true change of the combined condition. A held condition, or a handover from one true source to another, raises nothing.
- R7: While the display-enable input is low, no request is produced. If a source is already true when the display is enabled, one request follows two cycles later.
- R8: With the legacy input high and the display enabled, a status write while the registered mode is 0 or 1 raises a request in the cycle after the write. No such request occurs in mode 2 or 3, or with the legacy input low.
- R9: A status write that makes an already-true source enabled produces a request two cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Display enabled |
| mode_in | input | 2 | Current display mode |
| line_in | input | LINE_W | Current scan-line counter |
| cmp_in | input | LINE_W | Line-compare value |
| legacy_en | input | 1 | Enables the write-triggered legacy request |
| wr_en | input | 1 | CPU write strobe for the status register |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Status register read value |
| stat_irq | output | 1 | One-cycle status interrupt request |

## Verification
The assertions check four things on every cycle. Bits 6:3 take the written value one cycle after a write. The line-match flag never reads 1 without an equal line and compare value in the previous cycle. A request never follows a cycle with the display disabled. A legacy write in mode 0 or 1 is always followed by a request, and mode 3 without a line-match source is never followed by one.

Only the directed scenarios can show the rest. This covers each mode source firing with its own enable, and the absence of a pulse when the condition is held or handed between sources. It also covers the pulse on re-enabling the display and the pulse caused by a write that enables a source which is already true.

// File: rtl/lcd_stat_pkg.sv
package lcd_stat_pkg;
  typedef enum logic [1:0] {
    MODE_HBL  = 2'd0,
    MODE_VBL  = 2'd1,
    MODE_SCAN = 2'd2,
    MODE_XFER = 2'd3
  } lcd_mode_e;

  // bit positions inside the status byte
  localparam int STAT_W     = 8;
  localparam int EN_LO      = 3;
  localparam int EN_HI      = 6;
  localparam int EN_W       = EN_HI - EN_LO + 1;
  localparam int MATCH_BIT  = 2;
  // enable index of the line-compare source inside the enable field
  localparam int EN_MATCH   = EN_W - 1;
  // number of modes that may act as a source (modes 0..2)
  localparam int N_MODE_SRC = 3;
endpackage

// File: rtl/lcd_stat_regs.sv
module lcd_stat_regs
  import lcd_stat_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [STAT_W-1:0]   wr_data,
  input  logic [1:0]          mode_in,
  input  logic [LINE_W-1:0]   line_in,
  input  logic [LINE_W-1:0]   cmp_in,
  input  logic                disp_en,
  output logic [EN_W-1:0]     en_q,
  output logic                match_q,
  output logic [1:0]          mode_q,
  output logic                disp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      match_q <= 1'b0;
      mode_q  <= MODE_HBL;
      disp_q  <= 1'b0;
    end else begin
      if (wr_en) en_q <= wr_data[EN_HI:EN_LO];
      match_q <= (line_in == cmp_in);
      mode_q  <= mode_in;
      disp_q  <= disp_en;
    end
  end
endmodule

// File: rtl/lcd_stat_cond.sv
module lcd_stat_cond
  import lcd_stat_pkg::*;
(
  input  logic [EN_W-1:0] en_i,
  input  logic            match_i,
  input  logic [1:0]      mode_i,
  input  logic            disp_i,
  output logic            cond_o
);
  logic [N_MODE_SRC-1:0] mode_src;

  for (genvar g = 0; g < N_MODE_SRC; g++) begin : g_mode_src
    assign mode_src[g] = en_i[g] && (mode_i == 2'(g));
  end

  assign cond_o = disp_i && ((match_i && en_i[EN_MATCH]) || (|mode_src));
endmodule

// File: rtl/lcd_stat_irq_gen.sv
module lcd_stat_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  input  logic legacy_i,
  input  logic wr_en_i,
  input  logic mode_hi_i,
  input  logic disp_i,
  output logic irq_o
);
  logic cond_prev;
  logic quirk_hit;

  assign quirk_hit = legacy_i && wr_en_i && !mode_hi_i && disp_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_prev <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      cond_prev <= cond_i;
      irq_o     <= (cond_i && !cond_prev) || quirk_hit;
    end
  end

  assert_off_silent_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(disp_i));

  assert_quirk_fires_R8: assert property (@(posedge clk) disable iff (rst)
    (legacy_i && wr_en_i && !mode_hi_i && disp_i) |=> irq_o);
endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
  import lcd_stat_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_en,
  input  logic [1:0]        mode_in,
  input  logic [LINE_W-1:0] line_in,
  input  logic [LINE_W-1:0] cmp_in,
  input  logic              legacy_en,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              stat_irq
);
  logic [EN_W-1:0] en_q;
  logic            match_q;
  logic [1:0]      mode_q;
  logic            disp_q;
  logic            cond;

  lcd_stat_regs #(.LINE_W(LINE_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mode_in (mode_in),
    .line_in (line_in),
    .cmp_in  (cmp_in),
    .disp_en (disp_en),
    .en_q    (en_q),
    .match_q (match_q),
    .mode_q  (mode_q),
    .disp_q  (disp_q)
  );

  lcd_stat_cond u_cond (
    .en_i    (en_q),
    .match_i (match_q),
    .mode_i  (mode_q),
    .disp_i  (disp_q),
    .cond_o  (cond)
  );

  lcd_stat_irq_gen u_irq (
    .clk       (clk),
    .rst       (rst),
    .cond_i    (cond),
    .legacy_i  (legacy_en),
    .wr_en_i   (wr_en),
    .mode_hi_i (mode_q[1]),
    .disp_i    (disp_q),
    .irq_o     (stat_irq)
  );

  assign rd_data = {1'b1, en_q, match_q, mode_q};

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[7] && rd_data[EN_HI:EN_LO] == $past(wr_data[EN_HI:EN_LO])));

  assert_match_source_R3: assert property (@(posedge clk) disable iff (rst)
    rd_data[MATCH_BIT] |-> $past(line_in == cmp_in));

  assert_xfer_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_data[1:0] == 2'd3 && !(rd_data[MATCH_BIT] && rd_data[EN_HI])) |=> !stat_irq);
endmodule

// File: tb/tb_lcd_stat_irq.sv
`timescale 1ns/1ps
module tb_lcd_stat_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disp_en = 1'b1;
  logic [1:0] mode_in = 2'd3;
  logic [7:0] line_in = 8'd0;
  logic [7:0] cmp_in = 8'd5;
  logic       legacy_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       stat_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcd_stat_irq dut (
    .clk(clk), .rst(rst), .disp_en(disp_en), .mode_in(mode_in),
    .line_in(line_in), .cmp_in(cmp_in), .legacy_en(legacy_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .stat_irq(stat_irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    step(2);
    check("R1 rd", rd_data, 8'h80);
    check("R1 irq", {7'd0, stat_irq}, 8'd0);
    rst = 1'b0;
    step(2);
  endtask

  task automatic t_readback;
    line_in = 8'd0; mode_in = 2'd3; step(2);
    cpu_write(8'hFF);
    check("R2 all", rd_data, 8'hFB);
    check("R2 irq", {7'd0, stat_irq}, 8'd0);
    cpu_write(8'h87);
    check("R2 ignored bits", rd_data, 8'h83);
    cpu_write(8'h00);
    step(2);
  endtask

  task automatic t_match;
    line_in = 8'd5; step(1);
    check("R3 set", {7'd0, rd_data[2]}, 8'd1);
    line_in = 8'd6; step(1);
    check("R3 clear", {7'd0, rd_data[2]}, 8'd0);
    check("R3 no irq", {7'd0, stat_irq}, 8'd0);
  endtask

  task automatic t_lyc;
    cpu_write(8'h40); step(3);
    line_in = 8'd5;
    step(1); check("R4 early", {7'd0, stat_irq}, 8'd0);
    step(1); check("R4 pulse", {7'd0, stat_irq}, 8'd1);
    step(1); check("R6 held level", {7'd0, stat_irq}, 8'd0);
    step(2); check("R6 still held", {7'd0, stat_irq}, 8'd0);
    line_in = 8'd6; step(3);
  endtask

  task automatic t_modes;
    mode_in = 2'd3; cpu_write(8'h38); step(3);
    for (int m = 0; m < 3; m++) begin
      mode_in = 2'd3; step(3);
      mode_in = 2'(m);
      step(1); check("R5 early", {7'd0, stat_irq}, 8'd0);
      step(1); check("R5 mode source", {7'd0, stat_irq}, 8'd1);
    end
    mode_in = 2'd3; step(1);
    step(1); check("R5 mode3 silent", {7'd0, stat_irq}, 8'd0);
    step(1); check("R5 mode3 silent later", {7'd0, stat_irq}, 8'd0);
    cpu_write(8'h08); step(2);
    mode_in = 2'd1; step(2);
    check("R5 disabled mode1", {7'd0, stat_irq}, 8'd0);
    mode_in = 2'd3; step(2);
    mode_in = 2'd0; step(2);
    check("R5 only mode0", {7'd0, stat_irq}, 8'd1);
    mode_in = 2'd3; step(3);
  endtask

  task automatic t_edge;
    cpu_write(8'h38); mode_in = 2'd0; step(4);
    mode_in = 2'd1;
    step(1); check("R6 handover a", {7'd0, stat_irq}, 8'd0);
    step(1); check("R6 handover b", {7'd0, stat_irq}, 8'd0);
    mode_in = 2'd2; step(2);
    check("R6 handover c", {7'd0, stat_irq}, 8'd0);
    mode_in = 2'd3; step(3);
  endtask

  task automatic t_disp;
    cpu_write(8'h40); line_in = 8'd6; step(3);
    disp_en = 1'b0; step(2);
    line_in = 8'd5;
    for (int i = 0; i < 3; i++) begin
      step(1); check("R7 off", {7'd0, stat_irq}, 8'd0);
    end
    disp_en = 1'b1;
    step(1); check("R7 enable early", {7'd0, stat_irq}, 8'd0);
    step(1); check("R7 enable pulse", {7'd0, stat_irq}, 8'd1);
    line_in = 8'd6; step(3);
  endtask

  task automatic t_quirk;
    legacy_en = 1'b0; cpu_write(8'h00); mode_in = 2'd0; step(4);
    legacy_en = 1'b1;
    cpu_write(8'h00);
    check("R8 mode0 pulse", {7'd0, stat_irq}, 8'd1);
    step(1); check("R8 one cycle", {7'd0, stat_irq}, 8'd0);
    mode_in = 2'd2; step(2);
    cpu_write(8'h00);
    check("R8 mode2 none", {7'd0, stat_irq}, 8'd0);
    mode_in = 2'd3; step(2);
    cpu_write(8'h00);
    check("R8 mode3 none", {7'd0, stat_irq}, 8'd0);
    mode_in = 2'd1; step(2);
    cpu_write(8'h00);
    check("R8 mode1 pulse", {7'd0, stat_irq}, 8'd1);
    step(1);
    legacy_en = 1'b0; mode_in = 2'd0; step(2);
    cpu_write(8'h00);
    check("R8 legacy off", {7'd0, stat_irq}, 8'd0);
    legacy_en = 1'b1; disp_en = 1'b0; step(2);
    cpu_write(8'h00);
    check("R7 quirk gated", {7'd0, stat_irq}, 8'd0);
    legacy_en = 1'b0; disp_en = 1'b1; mode_in = 2'd3; step(3);
  endtask

  task automatic t_write_reeval;
    cpu_write(8'h00); line_in = 8'd5; step(4);
    cpu_write(8'h40);
    check("R9 early", {7'd0, stat_irq}, 8'd0);
    step(1); check("R9 pulse", {7'd0, stat_irq}, 8'd1);
    step(1); check("R9 one cycle", {7'd0, stat_irq}, 8'd0);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_match();
    t_lyc();
    t_modes();
    t_edge();
    t_disp();
    t_quirk();
    t_write_reeval();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule